// File: doc/BRIEF.md
# Adaptive Sequential Prefetch Controller

This controller sits next to a cache and turns demand misses into hardware prefetch requests for the blocks that follow the missing one. When a miss to block address A is reported, it emits the addresses A+1, A+2, ... up to the current lookahead depth. The addresses go out as a valid/ready stream, one block address per accepted handshake. The cache fetches each block and sets that block's prefetch tag bit.

The depth is not fixed. The controller counts its own accepted prefetch requests in windows of a fixed size. It also counts how many demand accesses land on blocks whose prefetch tag is still set. When a window closes, the useful count is compared against two thresholds, and the depth is stepped up, stepped down or left alone. After each counted hit a clear strobe tells the cache to drop the block's tag, so that the block is counted only once.

When the depth has fallen to zero, no prefetches are issued. Instead, each miss produces a zero-mark strobe that names the next sequential block. The cache sets a zero bit on that block when it is filled. A later demand access that reports this zero bit shows that the stream is sequential again, and it restores the depth to one.

Top module: `adaptive_prefetcher`

## Requirements
- R1: After reset the lookahead output is 1, and pf_valid, clr_tag and zmark_valid are 0.
- R2: A miss to address A that starts a sequence with depth K>0 produces exactly the addresses A+1 through A+K, modulo 2^ADDR_W, in ascending order. One address is issued per accepted pf_valid/pf_ready handshake. While pf_ready is low, pf_valid and pf_addr hold their values.
- R3: A miss that arrives while a sequence is running is held in a single slot. A later miss in the same situation replaces the held one. The held miss starts its own sequence after the current one ends, and a replaced miss is never issued.
- R4: The depth K of a sequence is the lookahead value when the sequence starts. A lookahead change during the sequence does not shorten or lengthen it.
- R5: When WINDOW handshakes have been counted, the window is evaluated. A useful count strictly greater than UP_TH raises lookahead by 1.
- R6: At evaluation, a useful count strictly below LO_TH lowers lookahead by 1. A count from LO_TH to UP_TH inclusive leaves it unchanged.
- R7: Lookahead saturates: it never exceeds LA_MAX and never goes below 0.
- R8: A demand access reporting a set prefetch tag raises clr_tag for one cycle, starting one cycle later, and counts one useful hit.
- R9: With lookahead 0, a miss to A issues no prefetch. It raises zmark_valid for one cycle, one cycle after the sequence slot takes it, with zmark_addr = A+1.
- R10: A demand access reporting a set zero tag while lookahead is 0 sets lookahead to 1 and raises clr_tag one cycle later. While lookahead is above 0, the zero tag is ignored: no clr_tag, no lookahead change.
- R11: Both the handshake count and the useful count restart from zero after each evaluation. Hits counted in one window do not carry into the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| miss_valid | input | 1 | Demand miss strobe |
| miss_addr | input | ADDR_W | Block address of the demand miss |
| acc_valid | input | 1 | Demand access strobe |
| acc_pf_tag | input | 1 | Prefetch tag bit of the accessed block |
| acc_zero_tag | input | 1 | Zero bit of the accessed block |
| pf_valid | output | 1 | Prefetch request valid |
| pf_ready | input | 1 | Prefetch request accepted by the cache |
| pf_addr | output | ADDR_W | Block address to prefetch |
| clr_tag | output | 1 | Clear the tag bits of the block just accessed |
| zmark_valid | output | 1 | Set the zero bit on the named block |
| zmark_addr | output | ADDR_W | Block that should receive the zero bit |
| lookahead | output | LA_W | Current prefetch depth |

## Verification
A miss sampled while the controller is idle shows pf_valid one cycle later, and each later address appears one cycle after the previous handshake. A held miss starts only after one idle cycle that follows the last handshake. clr_tag and zmark_valid are due exactly one cycle after the access or miss that causes them. A lookahead change appears at the end of the cycle that follows the window's closing handshake. The bench drives inputs and reads outputs on falling clock edges. It checks each strobe on the edge after its cause and the one after that. It reads lookahead only after a gap of idle cycles following the last handshake. It places demand accesses only in quiet stretches, so that none of them lands in an evaluation cycle. The bench keeps an arithmetic model of the two counters and the depth, and it sweeps useful counts on both sides of and exactly at each threshold.

// File: rtl/apf_pkg.sv
package apf_pkg;

  // Outcome of comparing a closed window's useful count with the thresholds
  typedef enum logic [1:0] {
    VERDICT_KEEP   = 2'd0,
    VERDICT_GROW   = 2'd1,
    VERDICT_SHRINK = 2'd2
  } verdict_e;

endpackage

// File: rtl/apf_rst_sync.sv
module apf_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [1:0] sync_q;

  // Assert at once, deassert after two clock edges
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n = sync_q[1];

endmodule

// File: rtl/apf_seq.sv
module apf_seq #(
  parameter int ADDR_W = 32,
  parameter int DEP_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              miss_v,
  input  logic [ADDR_W-1:0] miss_a,
  input  logic [DEP_W-1:0]  depth,
  input  logic              req_ready,
  output logic              req_valid,
  output logic [ADDR_W-1:0] req_addr,
  output logic              req_fire,
  output logic              zm_valid,
  output logic [ADDR_W-1:0] zm_addr
);

  localparam logic [ADDR_W-1:0] ONE_A = ADDR_W'(1);
  localparam logic [DEP_W-1:0]  ONE_D = DEP_W'(1);
  localparam logic [DEP_W-1:0]  NIL_D = '0;

  logic              busy_q, busy_n;
  logic [ADDR_W-1:0] cur_q, cur_n;
  logic [DEP_W-1:0]  left_q, left_n;
  logic              held_v_q, held_v_n;
  logic [ADDR_W-1:0] held_a_q, held_a_n;
  logic              zm_q, zm_n;
  logic [ADDR_W-1:0] zma_q, zma_n;

  logic              start;
  logic [ADDR_W-1:0] start_a;

  always_comb begin
    start    = !busy_q && (held_v_q || miss_v);
    start_a  = held_v_q ? held_a_q : miss_a;
    req_fire = busy_q && req_ready;

    // Single hold slot: the latest miss seen while the slot cannot start wins
    held_v_n = held_v_q;
    held_a_n = held_a_q;
    if (busy_q || held_v_q) begin
      if (!busy_q) held_v_n = 1'b0;
      if (miss_v) begin
        held_v_n = 1'b1;
        held_a_n = miss_a;
      end
    end

    busy_n = busy_q;
    cur_n  = cur_q;
    left_n = left_q;
    if (start) begin
      busy_n = (depth != NIL_D);
      cur_n  = start_a + ONE_A;
      left_n = depth;
    end else if (req_fire) begin
      cur_n  = cur_q + ONE_A;
      left_n = left_q - ONE_D;
      if (left_q == ONE_D) busy_n = 1'b0;
    end

    zm_n  = start && (depth == NIL_D);
    zma_n = start ? (start_a + ONE_A) : zma_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      cur_q    <= '0;
      left_q   <= '0;
      held_v_q <= 1'b0;
      held_a_q <= '0;
      zm_q     <= 1'b0;
      zma_q    <= '0;
    end else begin
      busy_q   <= busy_n;
      cur_q    <= cur_n;
      left_q   <= left_n;
      held_v_q <= held_v_n;
      held_a_q <= held_a_n;
      zm_q     <= zm_n;
      zma_q    <= zma_n;
    end
  end

  assign req_valid = busy_q;
  assign req_addr  = cur_q;
  assign zm_valid  = zm_q;
  assign zm_addr   = zma_q;

endmodule

// File: rtl/apf_window.sv
module apf_window
  import apf_pkg::*;
#(
  parameter int WINDOW = 16,
  parameter int UP_TH  = 12,
  parameter int LO_TH  = 8
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     req_fire,
  input  logic     hit,
  output logic     eval,
  output verdict_e verdict
);

  localparam int CNT_W = $clog2(WINDOW + 1);
  localparam logic [CNT_W-1:0] WIN_C = CNT_W'(WINDOW);
  localparam logic [CNT_W-1:0] UP_C  = CNT_W'(UP_TH);
  localparam logic [CNT_W-1:0] LO_C  = CNT_W'(LO_TH);

  logic [CNT_W-1:0] issued_q, issued_n;
  logic [CNT_W-1:0] useful_q, useful_n;
  logic [CNT_W-1:0] fire_inc, hit_inc;

  always_comb begin
    fire_inc = {{(CNT_W-1){1'b0}}, req_fire};
    hit_inc  = {{(CNT_W-1){1'b0}}, hit};
    eval     = (issued_q == WIN_C);

    if (useful_q > UP_C)      verdict = VERDICT_GROW;
    else if (useful_q < LO_C) verdict = VERDICT_SHRINK;
    else                      verdict = VERDICT_KEEP;

    // A closed window restarts; an event in the evaluation cycle opens the next one
    if (eval) begin
      issued_n = fire_inc;
      useful_n = hit_inc;
    end else begin
      issued_n = issued_q + fire_inc;
      useful_n = (useful_q == WIN_C) ? useful_q : (useful_q + hit_inc);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      issued_q <= '0;
      useful_q <= '0;
    end else begin
      issued_q <= issued_n;
      useful_q <= useful_n;
    end
  end

endmodule

// File: rtl/apf_degree.sv
module apf_degree
  import apf_pkg::*;
#(
  parameter int LA_MAX  = 4,
  parameter int LA_INIT = 1,
  localparam int LA_W   = $clog2(LA_MAX + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            eval,
  input  verdict_e        verdict,
  input  logic            wake,
  output logic [LA_W-1:0] depth
);

  localparam logic [LA_W-1:0] TOP_C  = LA_W'(LA_MAX);
  localparam logic [LA_W-1:0] INIT_C = LA_W'(LA_INIT);
  localparam logic [LA_W-1:0] ONE_C  = LA_W'(1);

  logic [LA_W-1:0] depth_q, depth_n;
  logic            upd_en;

  always_comb begin
    depth_n = depth_q;
    if (wake) begin
      depth_n = ONE_C;
    end else if (eval) begin
      if (verdict == VERDICT_GROW && depth_q != TOP_C)     depth_n = depth_q + ONE_C;
      else if (verdict == VERDICT_SHRINK && depth_q != '0) depth_n = depth_q - ONE_C;
    end
    upd_en = wake || eval;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      depth_q <= INIT_C;
    else if (upd_en) depth_q <= depth_n;
  end

  assign depth = depth_q;

endmodule

// File: rtl/adaptive_prefetcher.sv
module adaptive_prefetcher
  import apf_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LA_MAX = 4,
  parameter int WINDOW = 16,
  parameter int UP_TH  = 12,
  parameter int LO_TH  = 8,
  localparam int LA_W  = $clog2(LA_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              miss_valid,
  input  logic [ADDR_W-1:0] miss_addr,
  input  logic              acc_valid,
  input  logic              acc_pf_tag,
  input  logic              acc_zero_tag,
  output logic              pf_valid,
  input  logic              pf_ready,
  output logic [ADDR_W-1:0] pf_addr,
  output logic              clr_tag,
  output logic              zmark_valid,
  output logic [ADDR_W-1:0] zmark_addr,
  output logic [LA_W-1:0]   lookahead
);

  logic     srst_n;
  logic     req_fire;
  logic     hit;
  logic     wake;
  logic     eval;
  verdict_e verdict;
  logic     clr_q, clr_n;

  apf_rst_sync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  apf_seq #(.ADDR_W(ADDR_W), .DEP_W(LA_W)) u_seq (
    .clk       (clk),
    .rst_n     (srst_n),
    .miss_v    (miss_valid),
    .miss_a    (miss_addr),
    .depth     (lookahead),
    .req_ready (pf_ready),
    .req_valid (pf_valid),
    .req_addr  (pf_addr),
    .req_fire  (req_fire),
    .zm_valid  (zmark_valid),
    .zm_addr   (zmark_addr)
  );

  apf_window #(.WINDOW(WINDOW), .UP_TH(UP_TH), .LO_TH(LO_TH)) u_win (
    .clk      (clk),
    .rst_n    (srst_n),
    .req_fire (req_fire),
    .hit      (hit),
    .eval     (eval),
    .verdict  (verdict)
  );

  apf_degree #(.LA_MAX(LA_MAX), .LA_INIT(1)) u_deg (
    .clk     (clk),
    .rst_n   (srst_n),
    .eval    (eval),
    .verdict (verdict),
    .wake    (wake),
    .depth   (lookahead)
  );

  always_comb begin
    hit   = acc_valid && acc_pf_tag;
    wake  = acc_valid && acc_zero_tag && (lookahead == '0);
    clr_n = hit || wake;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) clr_q <= 1'b0;
    else         clr_q <= clr_n;
  end

  assign clr_tag = clr_q;

endmodule

// File: rtl/apf_checker.sv
module apf_checker #(
  parameter int ADDR_W = 32,
  parameter int LA_MAX = 4,
  localparam int LA_W  = $clog2(LA_MAX + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              acc_valid,
  input logic              acc_pf_tag,
  input logic              pf_valid,
  input logic              pf_ready,
  input logic [ADDR_W-1:0] pf_addr,
  input logic              zmark_valid,
  input logic              clr_tag,
  input logic [LA_W-1:0]   lookahead
);

  // R2: a stalled request keeps its address
  p_stall_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pf_valid && !pf_ready |=> pf_valid && $stable(pf_addr));

  // R2: after a handshake the next address, if any, is one higher
  p_ascend_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pf_valid && pf_ready |=> !pf_valid || (pf_addr == $past(pf_addr) + ADDR_W'(1)));

  // R7: depth never exceeds its ceiling
  p_la_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    int'(lookahead) <= LA_MAX);

  // R5 and R6: depth moves by one step at a time
  p_la_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    lookahead != $past(lookahead) |->
      (int'(lookahead) == int'($past(lookahead)) + 1) ||
      (int'(lookahead) + 1 == int'($past(lookahead))));

  // R8: a tagged access is followed by a clear strobe
  p_clr_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && acc_pf_tag |=> clr_tag);

  // R9: a zero mark never coincides with an outstanding request
  p_zmark_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    zmark_valid |-> !pf_valid);

endmodule

bind adaptive_prefetcher apf_checker #(.ADDR_W(ADDR_W), .LA_MAX(LA_MAX)) u_apf_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .acc_valid   (acc_valid),
  .acc_pf_tag  (acc_pf_tag),
  .pf_valid    (pf_valid),
  .pf_ready    (pf_ready),
  .pf_addr     (pf_addr),
  .zmark_valid (zmark_valid),
  .clr_tag     (clr_tag),
  .lookahead   (lookahead)
);

// File: tb/test_adaptive_prefetcher.sv
module test_adaptive_prefetcher;

  localparam int AW   = 32;
  localparam int LMAX = 4;
  localparam int WIN  = 16;
  localparam int UPT  = 12;
  localparam int LOT  = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          miss_valid;
  logic [AW-1:0] miss_addr;
  logic          acc_valid;
  logic          acc_pf_tag;
  logic          acc_zero_tag;
  logic          pf_valid;
  logic          pf_ready;
  logic [AW-1:0] pf_addr;
  logic          clr_tag;
  logic          zmark_valid;
  logic [AW-1:0] zmark_addr;
  logic [2:0]    lookahead;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  // Arithmetic model of depth and window counters
  int m_la = 1;
  int m_pf = 0;
  int m_use = 0;
  bit m_closed = 1'b0;
  logic [AW-1:0] next_base = 32'h0000_1000;

  always #4 clk = ~clk;

  adaptive_prefetcher #(
    .ADDR_W(AW), .LA_MAX(LMAX), .WINDOW(WIN), .UP_TH(UPT), .LO_TH(LOT)
  ) i_adaptive_prefetcher (
    .clk(clk), .rst_n(rst_n),
    .miss_valid(miss_valid), .miss_addr(miss_addr),
    .acc_valid(acc_valid), .acc_pf_tag(acc_pf_tag), .acc_zero_tag(acc_zero_tag),
    .pf_valid(pf_valid), .pf_ready(pf_ready), .pf_addr(pf_addr),
    .clr_tag(clr_tag), .zmark_valid(zmark_valid), .zmark_addr(zmark_addr),
    .lookahead(lookahead)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic void model_fire();
    m_pf++;
    if (m_pf == WIN) begin
      if (m_use > UPT && m_la < LMAX)      m_la++;
      else if (m_use < LOT && m_la > 0)    m_la--;
      m_pf = 0;
      m_use = 0;
      m_closed = 1'b1;
    end
  endfunction

  task automatic drive_miss(input logic [AW-1:0] a);
    @(negedge clk);
    miss_valid = 1'b1;
    miss_addr  = a;
    @(negedge clk);
    miss_valid = 1'b0;
  endtask

  // Accept k requests starting at base+1; pat>0 inserts stalls
  task automatic collect(input logic [AW-1:0] base, input int k, input int pat,
                         input bit tail_quiet, input string req);
    int got = 0;
    int spin = 0;
    int ph = 0;
    logic [AW-1:0] exp_a;
    while (got < k && spin < 400) begin
      @(negedge clk);
      spin++;
      pf_ready = (pat == 0) ? 1'b1 : ((ph % pat) != 0);
      ph++;
      if (pf_valid && pf_ready) begin
        exp_a = base + AW'(1 + got);
        chk(pf_addr == exp_a, req, pf_addr, exp_a);
        got++;
        model_fire();
      end
    end
    chk(got == k, "R2 R4 count", got, k);
    @(negedge clk);
    pf_ready = 1'b0;
    if (tail_quiet) begin
      repeat (2) @(negedge clk);
      chk(pf_valid == 1'b0, "R2 no extra request", pf_valid, 0);
    end
  endtask

  task automatic run_miss(input logic [AW-1:0] a, input int pat);
    int k;
    k = m_la;
    drive_miss(a);
    collect(a, k, pat, 1'b1, "R2 R4 address");
  endtask

  task automatic touch_pf(input int u);
    for (int i = 0; i < u; i++) begin
      @(negedge clk);
      acc_valid  = 1'b1;
      acc_pf_tag = 1'b1;
      @(negedge clk);
      acc_valid  = 1'b0;
      acc_pf_tag = 1'b0;
      chk(clr_tag == 1'b1, "R8 clear strobe", clr_tag, 1);
      if (m_use < WIN) m_use++;
    end
  endtask

  task automatic episode(input int u, input int pat, input string req);
    int n = 0;
    touch_pf(u);
    m_closed = 1'b0;
    while (!m_closed && n < 40) begin
      run_miss(next_base, pat);
      next_base = next_base + 32'h40;
      n++;
    end
    repeat (2) @(negedge clk);
    chk(int'(lookahead) == m_la, req, lookahead, m_la);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n        = 1'b0;
    miss_valid   = 1'b0;
    miss_addr    = '0;
    acc_valid    = 1'b0;
    acc_pf_tag   = 1'b0;
    acc_zero_tag = 1'b0;
    pf_ready     = 1'b0;
    repeat (3) @(negedge clk);
    chk(lookahead == 3'd1, "R1 depth in reset", lookahead, 1);
    chk(pf_valid == 1'b0 && clr_tag == 1'b0 && zmark_valid == 1'b0,
        "R1 strobes in reset", {pf_valid, clr_tag, zmark_valid}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(lookahead == 3'd1, "R1 depth after release", lookahead, 1);
    chk(pf_valid == 1'b0, "R1 idle after release", pf_valid, 0);

    // R2: address wraps at the top of the space
    run_miss(32'hFFFF_FFFF, 2);

    // R5 R6 R7 R11: threshold sweep, depth model 2,3,4,4,4,4,3,2,2,1,0
    episode(13, 0, "R5 above upper");
    episode(16, 2, "R5 full window");
    episode(16, 3, "R5 third step");
    episode(16, 0, "R7 ceiling");
    episode(12, 2, "R6 at upper");
    episode(8,  0, "R6 at lower");
    episode(7,  3, "R6 R11 below lower");
    episode(0,  0, "R4 R6 none useful");
    episode(9,  2, "R6 R11 middle");
    episode(0,  0, "R6 to one");
    episode(0,  3, "R6 to zero");
    chk(lookahead == 3'd0, "R7 floor reached", lookahead, 0);

    // R9: depth zero gives a zero mark, no request
    drive_miss(32'h0000_7000);
    chk(zmark_valid == 1'b1, "R9 zero mark", zmark_valid, 1);
    chk(zmark_addr == 32'h0000_7001, "R9 zero mark address", zmark_addr, 32'h7001);
    chk(pf_valid == 1'b0, "R9 no request", pf_valid, 0);
    @(negedge clk);
    chk(zmark_valid == 1'b0, "R9 one cycle", zmark_valid, 0);
    repeat (3) @(negedge clk);
    chk(pf_valid == 1'b0, "R9 still no request", pf_valid, 0);

    // R10: zero tag at depth zero restores depth one
    @(negedge clk);
    acc_valid    = 1'b1;
    acc_zero_tag = 1'b1;
    @(negedge clk);
    acc_valid    = 1'b0;
    acc_zero_tag = 1'b0;
    chk(clr_tag == 1'b1, "R10 clear on wake", clr_tag, 1);
    chk(lookahead == 3'd1, "R10 wake depth", lookahead, 1);
    m_la = 1;
    @(negedge clk);
    chk(clr_tag == 1'b0, "R10 clear one cycle", clr_tag, 0);

    // R3: misses while busy are held, the latest wins
    @(negedge clk);
    miss_valid = 1'b1;
    miss_addr  = 32'h0000_A000;
    @(negedge clk);
    miss_addr  = 32'h0000_B000;
    @(negedge clk);
    miss_addr  = 32'h0000_C000;
    @(negedge clk);
    miss_valid = 1'b0;
    chk(pf_valid == 1'b1 && pf_addr == 32'h0000_A001, "R3 first sequence", pf_addr, 32'hA001);
    collect(32'h0000_A000, 1, 2, 1'b0, "R3 first");
    collect(32'h0000_C000, 1, 0, 1'b1, "R3 held latest");

    // R10: zero tag ignored above depth zero; R8: untagged access gives no clear
    @(negedge clk);
    acc_valid    = 1'b1;
    acc_zero_tag = 1'b1;
    @(negedge clk);
    acc_valid    = 1'b0;
    acc_zero_tag = 1'b0;
    chk(clr_tag == 1'b0, "R10 ignored zero tag", clr_tag, 0);
    @(negedge clk);
    chk(int'(lookahead) == m_la, "R10 depth unchanged", lookahead, m_la);
    @(negedge clk);
    acc_valid = 1'b1;
    @(negedge clk);
    acc_valid = 1'b0;
    chk(clr_tag == 1'b0, "R8 untagged access", clr_tag, 0);

    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule